// File: doc/BRIEF.md
# Burst Window Register Address Generator

This block sits between a single burst data window and a peripheral register file. A block-transfer engine reads or writes the window over and over. On each access the block sends the access to a different register: the one at the register file's base address plus the sum of a programmed base offset and a running transfer index, with that sum scaled to 32-bit words (times four bytes).

Software writes a configuration port to set the base offset and the burst length. The transfer index is not under software control. It starts at zero and moves forward by one on every completed window handshake. After the access at an index equal to the burst length, it returns to zero, so one burst covers length plus one registers.

When offset plus index points past the last register of the file, the block does not reach the file. It holds the address at the last register, keeps the file enable low and returns zero read data. It raises an out-of-range flag and completes the handshake at once, so the transfer engine never stalls.

Top module: `burst_window_addr`

## Requirements
- R1: After reset the base offset, burst length and transfer index are all zero, so `rf_addr` equals `RF_BASE` and `win_oor` is low.
- R2: While offset plus index is below `NUM_REGS`, `rf_addr` equals `RF_BASE + 4*(offset + index)` and is word aligned.
- R3: The index moves forward by one only on a clock edge where `win_valid` and `win_ready` are both high. With either one low, `rf_addr` stays the same.
- R4: A handshake at an index equal to the programmed burst length returns the index to zero, so each burst covers burst length plus one consecutive registers.
- R5: A `cfg_we` pulse loads `cfg_base_off` and `cfg_burst_len` and clears the index to zero. It wins over a handshake in the same cycle.
- R6: When offset plus index is at least `NUM_REGS`:
  - `win_oor` is high.
  - `rf_addr` is held at `RF_BASE + 4*(NUM_REGS-1)`.
  - `rf_en` and `rf_we` are low.
  - `win_rdata` is zero.
  - `win_ready` is high whatever the value of `rf_ready`.
- R7: In range:
  - `rf_en` follows `win_valid`.
  - `rf_we` is `win_valid & win_write`.
  - `rf_wdata` equals `win_wdata`.
  - `win_rdata` equals `rf_rdata`.
  - `win_ready` equals `rf_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_base_off | input | OFF_W | New base register offset |
| cfg_burst_len | input | OFF_W | New burst length (last index) |
| win_valid | input | 1 | Window access request |
| win_write | input | 1 | Window access is a write |
| win_wdata | input | DW | Window write data |
| win_ready | output | 1 | Window access completes this cycle |
| win_rdata | output | DW | Window read data |
| win_oor | output | 1 | Current access is outside the register file |
| rf_en | output | 1 | Register file access enable |
| rf_we | output | 1 | Register file write enable |
| rf_addr | output | AW | Register file byte address |
| rf_wdata | output | DW | Register file write data |
| rf_rdata | input | DW | Register file read data |
| rf_ready | input | 1 | Register file accepts the access |

## Verification
Two kinds of result have different timing:
- The address, range flag, enables, read data and ready come through combinational paths from the current index and configuration. They are due as soon as the window inputs change.
- A handshake or a configuration write shows up in `rf_addr` only after the next rising edge.

The bench changes inputs on the falling edge and samples one time unit later, well before the next rising edge. The model index is updated only after that rising edge has passed. Stall cycles and idle cycles are sampled on the following falling edge, which confirms that the address did not move.

// File: rtl/burst_window_addr.sv
module burst_window_addr #(
  parameter int AW = 12,
  parameter int DW = 32,
  parameter int OFF_W = 5,
  parameter int NUM_REGS = 24,
  parameter logic [AW-1:0] RF_BASE = 'h100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [OFF_W-1:0] cfg_base_off,
  input  logic [OFF_W-1:0] cfg_burst_len,
  input  logic             win_valid,
  input  logic             win_write,
  input  logic [DW-1:0]    win_wdata,
  output logic             win_ready,
  output logic [DW-1:0]    win_rdata,
  output logic             win_oor,
  output logic             rf_en,
  output logic             rf_we,
  output logic [AW-1:0]    rf_addr,
  output logic [DW-1:0]    rf_wdata,
  input  logic [DW-1:0]    rf_rdata,
  input  logic             rf_ready
);
  localparam int SW = OFF_W + 1;
  localparam logic [AW-1:0] LAST_ADDR = RF_BASE + AW'((NUM_REGS - 1) * 4);

  logic [OFF_W-1:0] base_q, len_q, idx_q;
  logic [SW-1:0]    slot;
  logic             fire;

  assign slot      = {1'b0, base_q} + {1'b0, idx_q};
  assign win_oor   = (int'(slot) >= NUM_REGS);
  assign rf_addr   = win_oor ? LAST_ADDR : RF_BASE + (AW'(slot) << 2);
  assign win_ready = win_oor | rf_ready;
  assign rf_en     = win_valid & ~win_oor;
  assign rf_we     = rf_en & win_write;
  assign rf_wdata  = win_wdata;
  assign win_rdata = win_oor ? '0 : rf_rdata;
  assign fire      = win_valid & win_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
      idx_q  <= '0;
    end else if (cfg_we) begin
      base_q <= cfg_base_off;
      len_q  <= cfg_burst_len;
      idx_q  <= '0;
    end else if (fire) begin
      idx_q <= (idx_q == len_q) ? '0 : idx_q + OFF_W'(1);
    end
  end
endmodule

// File: rtl/burst_window_addr_chk.sv
module burst_window_addr_chk #(
  parameter int AW = 12,
  parameter int DW = 32,
  parameter int OFF_W = 5,
  parameter int NUM_REGS = 24,
  parameter logic [AW-1:0] RF_BASE = 'h100
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [OFF_W-1:0] cfg_base_off,
  input logic             win_valid,
  input logic             win_ready,
  input logic [DW-1:0]    win_rdata,
  input logic             win_oor,
  input logic             rf_en,
  input logic             rf_we,
  input logic [AW-1:0]    rf_addr,
  input logic             rf_ready
);
  localparam logic [AW-1:0] LAST_ADDR = RF_BASE + AW'((NUM_REGS - 1) * 4);

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(win_valid && win_ready) && !cfg_we) |=> $stable(rf_addr)); // R3

  AST_CFG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> rf_addr == ((int'($past(cfg_base_off)) >= NUM_REGS) ? LAST_ADDR
                           : RF_BASE + (AW'($past(cfg_base_off)) << 2))); // R5

  AST_STEP_OR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && win_ready && !cfg_we && !win_oor) |=>
      (win_oor || rf_addr == $past(rf_addr) + AW'(4) || rf_addr <= $past(rf_addr))); // R4

  AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    rf_addr[1:0] == 2'b00); // R2

  AST_OOR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    win_oor |-> (!rf_en && !rf_we && win_rdata == '0 && win_ready && rf_addr == LAST_ADDR)); // R6

  AST_PASS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_oor && win_valid) |-> (rf_en && win_ready == rf_ready)); // R7
endmodule

bind burst_window_addr burst_window_addr_chk #(
  .AW(AW), .DW(DW), .OFF_W(OFF_W), .NUM_REGS(NUM_REGS), .RF_BASE(RF_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_base_off(cfg_base_off),
  .win_valid(win_valid), .win_ready(win_ready), .win_rdata(win_rdata),
  .win_oor(win_oor), .rf_en(rf_en), .rf_we(rf_we), .rf_addr(rf_addr),
  .rf_ready(rf_ready)
);

// File: tb/sim_burst_window_addr.sv
module sim_burst_window_addr;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12, DW = 32, OFF_W = 5, NUM_REGS = 24;
  localparam logic [AW-1:0] RF_BASE = 'h100;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [OFF_W-1:0] cfg_base_off = 0, cfg_burst_len = 0;
  logic win_valid = 0, win_write = 0, rf_ready = 0;
  logic [DW-1:0] win_wdata = 0;
  logic win_ready, win_oor, rf_en, rf_we;
  logic [DW-1:0] win_rdata, rf_wdata, rf_rdata;
  logic [AW-1:0] rf_addr;

  int vectors = 0, miscompares = 0;
  int m_base = 0, m_len = 0, m_idx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign rf_rdata = {20'h5A5A5, rf_addr};

  burst_window_addr #(.AW(AW), .DW(DW), .OFF_W(OFF_W), .NUM_REGS(NUM_REGS), .RF_BASE(RF_BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_base_off(cfg_base_off),
    .cfg_burst_len(cfg_burst_len), .win_valid(win_valid), .win_write(win_write),
    .win_wdata(win_wdata), .win_ready(win_ready), .win_rdata(win_rdata), .win_oor(win_oor),
    .rf_en(rf_en), .rf_we(rf_we), .rf_addr(rf_addr), .rf_wdata(rf_wdata),
    .rf_rdata(rf_rdata), .rf_ready(rf_ready));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_oor();
    return (m_base + m_idx) >= NUM_REGS;
  endfunction

  function automatic logic [AW-1:0] exp_addr();
    if (exp_oor()) return RF_BASE + AW'((NUM_REGS - 1) * 4);
    return RF_BASE + AW'((m_base + m_idx) * 4);
  endfunction

  function automatic void advance();
    m_idx = (m_idx == m_len) ? 0 : m_idx + 1;
  endfunction

  task automatic check_outputs();
    string ra;
    ra = exp_oor() ? "R6" : "R2";
    chk(rf_addr == exp_addr(), ra, "rf_addr", 64'(rf_addr), 64'(exp_addr()));
    chk(win_oor == exp_oor(), "R6", "win_oor", 64'(win_oor), 64'(exp_oor()));
    if (exp_oor()) begin
      chk(!rf_en && !rf_we, "R6", "rf_en/rf_we", 64'({rf_en, rf_we}), 64'(0));
      chk(win_rdata == 0, "R6", "win_rdata", 64'(win_rdata), 64'(0));
      chk(win_ready == 1'b1, "R6", "win_ready", 64'(win_ready), 64'(1));
    end else begin
      chk(rf_en == win_valid, "R7", "rf_en", 64'(rf_en), 64'(win_valid));
      chk(rf_we == (win_valid & win_write), "R7", "rf_we", 64'(rf_we), 64'(win_valid & win_write));
      chk(win_rdata == {20'h5A5A5, exp_addr()}, "R7", "win_rdata", 64'(win_rdata),
          64'({20'h5A5A5, exp_addr()}));
      chk(win_ready == rf_ready, "R7", "win_ready", 64'(win_ready), 64'(rf_ready));
      if (win_write)
        chk(rf_wdata == win_wdata, "R7", "rf_wdata", 64'(rf_wdata), 64'(win_wdata));
    end
  endtask

  task automatic configure(input int b, input int l);
    @(negedge clk);
    win_valid = 0;
    cfg_we = 1; cfg_base_off = OFF_W'(b); cfg_burst_len = OFF_W'(l);
    @(negedge clk);
    cfg_we = 0;
    m_base = b; m_len = l; m_idx = 0;
  endtask

  task automatic xfer(input bit stall, input bit wr, input int tag);
    @(negedge clk);
    win_valid = 1; win_write = wr; win_wdata = 32'hC0DE_0000 + tag;
    if (stall && !exp_oor()) begin
      rf_ready = 0;
      #1 check_outputs();
      @(negedge clk);
      chk(rf_addr == exp_addr(), "R3", "stall rf_addr", 64'(rf_addr), 64'(exp_addr()));
    end
    rf_ready = 1;
    #1 check_outputs();
    @(posedge clk);
    advance();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++; vectors++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(rf_addr == RF_BASE, "R1", "reset rf_addr", 64'(rf_addr), 64'(RF_BASE));
    chk(win_oor == 1'b0, "R1", "reset win_oor", 64'(win_oor), 64'(0));
    @(negedge clk);
    rst_n = 1;
    #1;
    chk(rf_addr == RF_BASE, "R1", "post-reset rf_addr", 64'(rf_addr), 64'(RF_BASE));

    // R4: default length 0 keeps the burst on a single register
    xfer(0, 0, 1);
    xfer(0, 1, 2);

    // R2 R4 R6 R7: every offset and length, two full bursts each, with stalls
    for (int b = 0; b < 32; b++) begin
      for (int l = 0; l < 32; l++) begin
        configure(b, l);
        for (int t = 0; t < 2 * (l + 1); t++)
          xfer((t % 5) == 2, t[0], t);
      end
    end

    // R3: valid low with ready high does not advance
    configure(3, 6);
    xfer(0, 0, 0);
    @(negedge clk);
    win_valid = 0; rf_ready = 1;
    @(negedge clk);
    chk(rf_addr == exp_addr(), "R3", "idle rf_addr", 64'(rf_addr), 64'(exp_addr()));

    // R5: configuration write mid-burst wins over a simultaneous handshake
    xfer(0, 0, 0);
    @(negedge clk);
    win_valid = 1; rf_ready = 1;
    cfg_we = 1; cfg_base_off = 5'd10; cfg_burst_len = 5'd2;
    @(negedge clk);
    cfg_we = 0; win_valid = 0;
    m_base = 10; m_len = 2; m_idx = 0;
    #1;
    chk(rf_addr == RF_BASE + AW'(40), "R5", "cfg priority rf_addr", 64'(rf_addr), 64'(RF_BASE + AW'(40)));
    for (int t = 0; t < 4; t++) xfer(0, 1, t);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule